// File: doc/BRIEF.md
# Dual Wiper SPI Command Decoder

This block is the serial front end of a controller for two 6-bit digital wipers. It runs on a fast system clock and oversamples the SPI pins: chip select, serial clock, serial input, and a pause input. It also reads two address strap inputs. Serial data is captured on rising SCK edges and SO is updated on falling SCK edges, which is SPI mode 0. A frame opens with an identification byte that must match a fixed device tag and the straps. An instruction byte follows, and some commands then take a data byte.

Valid commands become single-word requests to a register bank. Each request carries a kind code, a wiper select, a data-register select and, for writes, a 6-bit value. The request port is valid/ready. A request holds its payload until it is taken. The bank answers read requests with one `rsp_valid` pulse, and the decoder accepts every such pulse it is waiting for. After the step opcode, the frame becomes a stream: each SCK rising edge becomes one step request, whose direction is given by the SI level at that edge. The bank must accept each request within one SPI bit time. A request issued while the previous one is still held is discarded.

Top module: `dpot_spi_decoder`

## Requirements
- R1: After reset, no frame starts until the synchronised `spi_cs_n` has been seen high and then low. SCK activity with chip select held low from reset issues nothing. Right after reset, `so_oe` and `req_valid` are low.
- R2: The first byte of a frame is sent MSB first. It must equal 0101 in bits 7:4, 00 in bits 3:2 and `addr_strap` in bits 1:0. On any mismatch the rest of the frame is ignored until chip select rises.
- R3: The second byte holds the opcode in bits 7:4, the data-register select in bits 3:2, a required 0 in bit 1 and the wiper select in bit 0. If bit 1 is 1, or the opcode is not in the command set, the frame issues nothing.
- R4: Transfer opcodes 1101 (register to wiper, kind 4), 1110 (wiper to register, kind 5), 0001 (both wipers from register, kind 6) and 1000 (both wipers to register, kind 7) issue one request when the second byte completes. The two both-wiper kinds report `req_pot` 0.
- R5: Write opcodes 1010 (wiper, kind 1) and 1100 (data register, kind 3) issue one request when the third byte completes. `req_wdata` is bits 5:0 of that byte.
- R6: Read opcodes 1001 (wiper, kind 0) and 1011 (data register, kind 2) issue one request when the second byte completes. During the third byte, SO carries {00, `rsp_data`} MSB first, and each bit is presented after an SCK falling edge.
- R7: Status opcode 0101 issues no request. During the third byte, SO carries seven zeros followed by the `wip` level as it stood when the second byte completed.
- R8: After opcode 0010, every SCK rising edge until chip select rises issues one request. The kind is 8 (step up) when SI is 1 and 9 (step down) when SI is 0.
- R9: Taking `spi_hold_n` low while SCK is low freezes the frame, and SCK edges are then ignored. Taking it high while SCK is low resumes the frame with no loss of state. While the frame is frozen, `so_oe` is low.
- R10: `so_oe` is low while chip select is high and high during an active, unpaused frame.
- R11: If chip select rises before a required byte is complete, the frame issues no request.
- R12: While `req_valid` is high and `req_ready` is low, `req_valid` and the request payload stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Active-low chip select pin |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Active-low pause |
| addr_strap | input | 2 | Device address straps |
| wip | input | 1 | Write-in-progress level from the bank |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Drive enable for SO (low means high impedance) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by bank |
| req_kind | output | 4 | Request kind code (R4 to R8) |
| req_pot | output | 1 | Wiper select |
| req_sel | output | 2 | Data register select |
| req_wdata | output | 6 | Write value |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | 6 | Read response value |

## Verification
A pin change takes two synchroniser stages and one edge-detect comparison before it is seen. A request therefore appears on `req_valid` four clock edges after the SCK rising edge that completes its byte. SO settles three clock edges after a falling SCK edge. The bench holds each SCK level for eight clocks and reads SO just before the next falling edge. It compares captured requests only after chip select has risen and three half-bits have passed. Outputs are read and pins are driven on the falling clock edge, so every result has at least four clocks of slack.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int WIPER_W = 6;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    K_RD_WIPER   = 4'd0,
    K_WR_WIPER   = 4'd1,
    K_RD_DREG    = 4'd2,
    K_WR_DREG    = 4'd3,
    K_DREG2WIPER = 4'd4,
    K_WIPER2DREG = 4'd5,
    K_ALL_D2W    = 4'd6,
    K_ALL_W2D    = 4'd7,
    K_STEP_UP    = 4'd8,
    K_STEP_DN    = 4'd9
  } req_kind_e;

  typedef enum logic [2:0] {
    FORM_XFER, FORM_READ, FORM_WRITE, FORM_STATUS, FORM_STEP
  } form_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ID, PH_INSTR, PH_DATA, PH_STEP, PH_SKIP
  } phase_e;

  typedef struct packed {
    req_kind_e           kind;
    logic                pot;
    logic [1:0]          sel;
    logic [WIPER_W-1:0]  wdata;
  } dpot_req_t;

  typedef struct packed {
    logic      ok;
    logic      global;
    form_e     form;
    req_kind_e kind;
  } dec_t;

  function automatic dec_t decode_op(input logic [3:0] op);
    dec_t d;
    d.ok     = 1'b1;
    d.global = 1'b0;
    d.form   = FORM_XFER;
    d.kind   = K_RD_WIPER;
    case (op)
      4'b1001: begin d.form = FORM_READ;  d.kind = K_RD_WIPER;   end
      4'b1011: begin d.form = FORM_READ;  d.kind = K_RD_DREG;    end
      4'b1010: begin d.form = FORM_WRITE; d.kind = K_WR_WIPER;   end
      4'b1100: begin d.form = FORM_WRITE; d.kind = K_WR_DREG;    end
      4'b1101: begin d.form = FORM_XFER;  d.kind = K_DREG2WIPER; end
      4'b1110: begin d.form = FORM_XFER;  d.kind = K_WIPER2DREG; end
      4'b0001: begin d.form = FORM_XFER;  d.kind = K_ALL_D2W; d.global = 1'b1; end
      4'b1000: begin d.form = FORM_XFER;  d.kind = K_ALL_W2D; d.global = 1'b1; end
      4'b0010: begin d.form = FORM_STEP;  d.kind = K_STEP_UP;    end
      4'b0101: begin d.form = FORM_STATUS; end
      default: d.ok = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/dpot_pin_sync.sv
module dpot_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic cs_n_pin,
  input  logic si_pin,
  input  logic hold_n_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic si_s,
  output logic held
);
  localparam int NSIG = 4;
  // bit order {hold_n, si, cs_n, sck}; cs_n resets low so a rise must come first
  localparam logic [NSIG-1:0] RST_VAL = 4'b1000;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  assign raw = {hold_n_pin, si_pin, cs_n_pin, sck_pin};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  logic sck_s, cs_n_s, hold_n_s;
  assign sck_s    = synced[0];
  assign cs_n_s   = synced[1];
  assign si_s     = synced[2];
  assign hold_n_s = synced[3];

  logic sck_q, cs_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_n_q <= 1'b0;
      held   <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      cs_n_q <= cs_n_s;
      if (cs_n_s)     held <= 1'b0;
      else if (!sck_s) held <= ~hold_n_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q & ~held & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_q & ~held & ~cs_n_s;
  assign cs_fall  = ~cs_n_s & cs_n_q;
  assign cs_rise  = cs_n_s & ~cs_n_q;
  assign cs_low   = ~cs_n_s;

  // R9: pause state only moves while SCK is low (or on deselect)
  assert_hold_sck_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held != $past(held)) |-> (!$past(sck_s) || $past(cs_n_s)));
endmodule

// File: rtl/dpot_frame_parser.sv
module dpot_frame_parser
  import dpot_pkg::*;
#(
  parameter logic [3:0] DEV_TAG = 4'b0101
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_fall,
  input  logic                cs_rise,
  input  logic                cs_low,
  input  logic                sck_rise,
  input  logic                si_s,
  input  logic [1:0]          strap,
  input  logic                wip,
  input  logic                rsp_valid,
  input  logic [WIPER_W-1:0]  rsp_data,
  output logic                issue,
  output dpot_req_t           issue_req,
  output logic [BYTE_W-1:0]   rd_byte,
  output logic [CNT_W-1:0]    bit_idx,
  output logic                in_frame,
  output logic                in_data
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e                phase;
  logic [CNT_W-1:0]      bitcnt;
  logic [BYTE_W-2:0]     shreg;
  form_e                 cur_form;
  logic                  cur_pot;
  logic [1:0]            cur_sel;
  logic                  await_rsp;

  logic [BYTE_W-1:0] byte_in;
  logic              byte_done;
  logic              id_match;
  dec_t              dec;
  logic              cmd_ok;
  logic              pot_v;

  assign byte_in   = {shreg, si_s};
  assign byte_done = (bitcnt == LAST_BIT);
  assign id_match  = (byte_in == {DEV_TAG, 2'b00, strap});
  assign dec       = decode_op(byte_in[7:4]);
  assign cmd_ok    = dec.ok & ~byte_in[1];
  assign pot_v     = dec.global ? 1'b0 : byte_in[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      cur_form  <= FORM_XFER;
      cur_pot   <= 1'b0;
      cur_sel   <= '0;
      await_rsp <= 1'b0;
      rd_byte   <= '0;
      issue     <= 1'b0;
      issue_req <= '0;
    end else begin
      issue <= 1'b0;
      if (await_rsp && rsp_valid) begin
        rd_byte   <= BYTE_W'(rsp_data);
        await_rsp <= 1'b0;
      end
      if (cs_rise) begin
        phase     <= PH_IDLE;
        await_rsp <= 1'b0;
      end else if (cs_fall) begin
        phase     <= PH_ID;
        bitcnt    <= '0;
        rd_byte   <= '0;
        await_rsp <= 1'b0;
      end else if (sck_rise && phase != PH_IDLE) begin
        shreg  <= byte_in[BYTE_W-2:0];
        bitcnt <= byte_done ? '0 : bitcnt + 1'b1;
        case (phase)
          PH_STEP: begin
            issue     <= 1'b1;
            issue_req <= '{kind: (si_s ? K_STEP_UP : K_STEP_DN), pot: cur_pot,
                           sel: cur_sel, wdata: '0};
          end
          PH_ID: if (byte_done) phase <= id_match ? PH_INSTR : PH_SKIP;
          PH_INSTR: if (byte_done) begin
            if (!cmd_ok) begin
              phase <= PH_SKIP;
            end else begin
              cur_form <= dec.form;
              cur_pot  <= pot_v;
              cur_sel  <= byte_in[3:2];
              case (dec.form)
                FORM_XFER: begin
                  issue     <= 1'b1;
                  issue_req <= '{kind: dec.kind, pot: pot_v, sel: byte_in[3:2], wdata: '0};
                  phase     <= PH_SKIP;
                end
                FORM_READ: begin
                  issue     <= 1'b1;
                  issue_req <= '{kind: dec.kind, pot: pot_v, sel: byte_in[3:2], wdata: '0};
                  await_rsp <= 1'b1;
                  phase     <= PH_DATA;
                end
                FORM_STATUS: begin
                  rd_byte <= BYTE_W'(wip);
                  phase   <= PH_DATA;
                end
                FORM_WRITE: phase <= PH_DATA;
                default:    phase <= PH_STEP;
              endcase
              // write kinds are held until the data byte arrives
              if (dec.form == FORM_WRITE) issue_req.kind <= dec.kind;
            end
          end
          PH_DATA: if (byte_done) begin
            if (cur_form == FORM_WRITE) begin
              issue     <= 1'b1;
              issue_req <= '{kind: issue_req.kind, pot: cur_pot, sel: cur_sel,
                             wdata: byte_in[WIPER_W-1:0]};
            end
            phase <= PH_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign bit_idx  = bitcnt;
  assign in_frame = (phase != PH_IDLE);
  assign in_data  = (phase == PH_DATA);

  // R4: requests are only raised from inside a selected frame
  assert_issue_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> $past(cs_low));
endmodule

// File: rtl/dpot_req_hold.sv
module dpot_req_hold
  import dpot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      issue,
  input  dpot_req_t issue_req,
  input  logic      req_ready,
  output logic      req_valid,
  output dpot_req_t req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_q     <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (issue && (!req_valid || req_ready)) begin
        req_valid <= 1'b1;
        req_q     <= issue_req;
      end
    end
  end

  assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_q)));
endmodule

// File: rtl/dpot_so_drive.sv
module dpot_so_drive
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              sck_fall,
  input  logic              in_frame,
  input  logic              in_data,
  input  logic              held,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              so_data,
  output logic              so_oe
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(BYTE_W - 1);

  logic so_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        so_q <= 1'b0;
    else if (cs_fall)  so_q <= 1'b0;
    else if (sck_fall) so_q <= in_data ? rd_byte[TOP - bit_idx] : 1'b0;
  end

  assign so_data = so_q;
  assign so_oe   = in_frame & ~held;

  // R6: SO only moves on a falling SCK edge or at frame start
  assert_so_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (so_q != $past(so_q)) |-> ($past(sck_fall) || $past(cs_fall)));
endmodule

// File: rtl/dpot_spi_decoder.sv
module dpot_spi_decoder
  import dpot_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TAG     = 4'b0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_si,
  input  logic               spi_hold_n,
  input  logic [1:0]         addr_strap,
  input  logic               wip,
  output logic               so_data,
  output logic               so_oe,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [3:0]         req_kind,
  output logic               req_pot,
  output logic [1:0]         req_sel,
  output logic [WIPER_W-1:0] req_wdata,
  input  logic               rsp_valid,
  input  logic [WIPER_W-1:0] rsp_data
);
  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_low, si_s, held;
  logic issue, in_frame, in_data;
  dpot_req_t issue_req, req_q;
  logic [BYTE_W-1:0] rd_byte;
  logic [CNT_W-1:0]  bit_idx;

  dpot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_pin(spi_sck), .cs_n_pin(spi_cs_n),
    .si_pin(spi_si), .hold_n_pin(spi_hold_n), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_low(cs_low), .si_s(si_s), .held(held));

  dpot_frame_parser #(.DEV_TAG(DEV_TAG)) u_parse (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_low(cs_low), .sck_rise(sck_rise), .si_s(si_s), .strap(addr_strap),
    .wip(wip), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .issue(issue),
    .issue_req(issue_req), .rd_byte(rd_byte), .bit_idx(bit_idx),
    .in_frame(in_frame), .in_data(in_data));

  dpot_req_hold u_req (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_req(issue_req),
    .req_ready(req_ready), .req_valid(req_valid), .req_q(req_q));

  dpot_so_drive u_so (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sck_fall(sck_fall),
    .in_frame(in_frame), .in_data(in_data), .held(held), .bit_idx(bit_idx),
    .rd_byte(rd_byte), .so_data(so_data), .so_oe(so_oe));

  assign req_kind  = req_q.kind;
  assign req_pot   = req_q.pot;
  assign req_sel   = req_q.sel;
  assign req_wdata = req_q.wdata;
endmodule

// File: tb/tb_dpot_spi_decoder.sv
module tb_dpot_spi_decoder;
  localparam int H  = 8;
  localparam int WD = 150000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b0, spi_si = 1'b0, spi_hold_n = 1'b1;
  logic [1:0] addr_strap = 2'b01;
  logic wip = 1'b0, req_ready = 1'b1, rsp_valid = 1'b0;
  logic [5:0] rsp_data = '0;
  logic so_data, so_oe, req_valid, req_pot;
  logic [3:0] req_kind;
  logic [1:0] req_sel;
  logic [5:0] req_wdata;

  dpot_spi_decoder dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_hold_n(spi_hold_n), .addr_strap(addr_strap),
    .wip(wip), .so_data(so_data), .so_oe(so_oe), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_pot(req_pot),
    .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data));

  int checks = 0, fails = 0, cap_n = 0;
  bit done = 0;
  int cap_kind [256];
  int cap_pot  [256];
  int cap_sel  [256];
  int cap_wd   [256];
  logic [5:0] bk_w [2];
  logic [5:0] bk_d [2][4];

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench-side register bank: records requests and answers reads
  always @(negedge clk) begin
    rsp_valid <= 1'b0;
    if (rst_n && req_valid && req_ready) begin
      cap_kind[cap_n & 255] = int'(req_kind);
      cap_pot [cap_n & 255] = int'(req_pot);
      cap_sel [cap_n & 255] = int'(req_sel);
      cap_wd  [cap_n & 255] = int'(req_wdata);
      cap_n++;
      case (req_kind)
        4'd0: begin rsp_valid <= 1'b1; rsp_data <= bk_w[req_pot]; end
        4'd2: begin rsp_valid <= 1'b1; rsp_data <= bk_d[req_pot][req_sel]; end
        4'd1: bk_w[req_pot] = req_wdata;
        4'd3: bk_d[req_pot][req_sel] = req_wdata;
        4'd4: bk_w[req_pot] = bk_d[req_pot][req_sel];
        4'd5: bk_d[req_pot][req_sel] = bk_w[req_pot];
        4'd6: for (int p = 0; p < 2; p++) bk_w[p] = bk_d[p][req_sel];
        4'd7: for (int p = 0; p < 2; p++) bk_d[p][req_sel] = bk_w[p];
        4'd8: if (bk_w[req_pot] != 6'd63) bk_w[req_pot] = bk_w[req_pot] + 6'd1;
        4'd9: if (bk_w[req_pot] != 6'd0)  bk_w[req_pot] = bk_w[req_pot] - 6'd1;
        default: ;
      endcase
    end
  end

  function automatic int exp_form(input logic [3:0] op);
    case (op)
      4'b1001, 4'b1011:                   return 2;
      4'b1010, 4'b1100:                   return 3;
      4'b1101, 4'b1110, 4'b0001, 4'b1000: return 1;
      4'b0010:                            return 5;
      4'b0101:                            return 4;
      default:                            return 0;
    endcase
  endfunction

  function automatic int exp_kind(input logic [3:0] op);
    case (op)
      4'b1001: return 0;  4'b1010: return 1;  4'b1011: return 2;
      4'b1100: return 3;  4'b1101: return 4;  4'b1110: return 5;
      4'b0001: return 6;  4'b1000: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [3:0] pick_op(input int i);
    case (i)
      0: return 4'b1001; 1: return 4'b1010; 2: return 4'b1011; 3: return 4'b1100;
      4: return 4'b1101; 5: return 4'b1110; 6: return 4'b0001; 7: return 4'b1000;
      8: return 4'b0010; default: return 4'b0101;
    endcase
  endfunction

  task automatic bit_xfer(input logic b, output logic o);
    spi_si = b;
    repeat (H) @(negedge clk);
    spi_sck = 1'b1;
    repeat (H) @(negedge clk);
    o = so_data;
    spi_sck = 1'b0;
  endtask

  task automatic do_hold();
    logic dummy;
    repeat (H) @(negedge clk);
    spi_hold_n = 1'b0;
    repeat (2*H) @(negedge clk);
    check_eq("R9 so_oe low while paused", int'(so_oe), 0);
    for (int k = 0; k < 3; k++) begin
      spi_si = k[0];
      repeat (H) @(negedge clk);
      spi_sck = 1'b1;
      repeat (H) @(negedge clk);
      spi_sck = 1'b0;
    end
    dummy = 1'b0;
    repeat (H) @(negedge clk);
    spi_hold_n = 1'b1;
    repeat (2*H) @(negedge clk);
    check_eq("R9 so_oe back after resume", int'(so_oe), 1 + int'(dummy));
  endtask

  task automatic byte_xfer(input logic [7:0] b, input int hold_at, input int nbits,
                           output logic [7:0] r);
    logic o;
    r = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      if (7 - i == hold_at) do_hold();
      bit_xfer(b[i], o);
      r[i] = o;
    end
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (3*H) @(negedge clk);
  endtask

  function automatic logic [7:0] id_byte(input logic [1:0] s);
    return {4'b0101, 2'b00, s};
  endfunction

  task automatic run_cmd(input logic [3:0] op, input logic pot, input logic [1:0] sel,
                         input logic bad1, input logic [7:0] data, input int nsteps,
                         input logic [7:0] dirs);
    int form, base, nexp, kexp, pexp;
    logic [7:0] instr, rb, dummy, exp_rb;
    logic o;
    form  = bad1 ? 0 : exp_form(op);
    base  = cap_n;
    instr = {op, sel, bad1, pot};
    kexp  = exp_kind(op);
    pexp  = (op == 4'b0001 || op == 4'b1000) ? 0 : int'(pot);
    exp_rb = '0;
    if (form == 2) exp_rb = (kexp == 0) ? {2'b00, bk_w[pot]} : {2'b00, bk_d[pot][sel]};
    if (form == 4) exp_rb = {7'b0, wip};
    cs_begin();
    byte_xfer(id_byte(addr_strap), 99, 8, dummy);
    byte_xfer(instr, 99, 8, dummy);
    rb = '0;
    if (form >= 2 && form <= 4) byte_xfer(data, 99, 8, rb);
    if (form == 5) for (int s = 0; s < nsteps; s++) bit_xfer(dirs[s], o);
    cs_end();
    nexp = (form == 5) ? nsteps : ((form >= 1 && form <= 3) ? 1 : 0);
    check_eq("R3 request count", cap_n - base, nexp);
    if (cap_n - base != nexp) return;
    case (form)
      1: begin
        check_eq("R4 transfer kind", cap_kind[base & 255], kexp);
        check_eq("R4 transfer pot",  cap_pot[base & 255], pexp);
        check_eq("R4 transfer sel",  cap_sel[base & 255], int'(sel));
      end
      2: begin
        check_eq("R6 read kind", cap_kind[base & 255], kexp);
        check_eq("R6 read pot",  cap_pot[base & 255], int'(pot));
        check_eq("R6 SO read byte", int'(rb), int'(exp_rb));
      end
      3: begin
        check_eq("R5 write kind",  cap_kind[base & 255], kexp);
        check_eq("R5 write pot",   cap_pot[base & 255], int'(pot));
        check_eq("R5 write sel",   cap_sel[base & 255], int'(sel));
        check_eq("R5 write value", cap_wd[base & 255], int'(data[5:0]));
      end
      4: check_eq("R7 status byte", int'(rb), int'(exp_rb));
      5: for (int s = 0; s < nsteps; s++) begin
        check_eq("R8 step kind", cap_kind[(base + s) & 255], dirs[s] ? 8 : 9);
        check_eq("R8 step pot",  cap_pot[(base + s) & 255], int'(pot));
      end
      default: ;
    endcase
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] dummy;
    logic [3:0] op;
    void'($urandom(32'd1234));
    for (int p = 0; p < 2; p++) begin
      bk_w[p] = 6'(p * 7 + 5);
      for (int r = 0; r < 4; r++) bk_d[p][r] = 6'(p * 16 + r * 3 + 1);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1 so_oe after reset", int'(so_oe), 0);
    check_eq("R1 req_valid after reset", int'(req_valid), 0);

    // R1: chip select low since reset, no edge -> nothing
    base = cap_n;
    byte_xfer(id_byte(addr_strap), 99, 8, dummy);
    byte_xfer(8'b1101_0100, 99, 8, dummy);
    repeat (3*H) @(negedge clk);
    check_eq("R1 no command without CS edge", cap_n - base, 0);
    spi_cs_n = 1'b1;
    repeat (3*H) @(negedge clk);
    check_eq("R10 so_oe low while deselected", int'(so_oe), 0);

    // R10 + basic transfer
    cs_begin();
    check_eq("R10 so_oe high in frame", int'(so_oe), 1);
    byte_xfer(id_byte(addr_strap), 99, 8, dummy);
    byte_xfer(8'b1101_1001, 99, 8, dummy);
    cs_end();
    check_eq("R4 transfer issued", cap_n - base, 1);

    // R2: wrong tag, wrong strap, nonzero middle bits
    base = cap_n;
    cs_begin(); byte_xfer(8'b0110_0001, 99, 8, dummy); byte_xfer(8'b1101_0000, 99, 8, dummy); cs_end();
    cs_begin(); byte_xfer(8'b0101_0010, 99, 8, dummy); byte_xfer(8'b1101_0000, 99, 8, dummy); cs_end();
    cs_begin(); byte_xfer(8'b0101_0101, 99, 8, dummy); byte_xfer(8'b1101_0000, 99, 8, dummy); cs_end();
    check_eq("R2 mismatched ID ignored", cap_n - base, 0);

    // R3: bit 1 set
    run_cmd(4'b1101, 1'b0, 2'b10, 1'b1, 8'h00, 0, 8'h00);

    // R11: early end in data byte and in instruction byte
    base = cap_n;
    cs_begin(); byte_xfer(id_byte(addr_strap), 99, 8, dummy);
    byte_xfer(8'b1010_0000, 99, 8, dummy); byte_xfer(8'h2A, 99, 4, dummy); cs_end();
    cs_begin(); byte_xfer(id_byte(addr_strap), 99, 8, dummy);
    byte_xfer(8'b1101_0000, 99, 5, dummy); cs_end();
    check_eq("R11 truncated frames issue nothing", cap_n - base, 0);

    // R9: pause in the middle of a write data byte
    base = cap_n;
    cs_begin(); byte_xfer(id_byte(addr_strap), 99, 8, dummy);
    byte_xfer(8'b1100_1101, 99, 8, dummy); byte_xfer(8'h1B, 3, 8, dummy); cs_end();
    check_eq("R9 one request after pause", cap_n - base, 1);
    check_eq("R9 data intact after pause", cap_wd[base & 255], 6'h1B);
    check_eq("R9 sel intact after pause", cap_sel[base & 255], 3);

    // R12: back-pressure
    req_ready = 1'b0;
    base = cap_n;
    cs_begin(); byte_xfer(id_byte(addr_strap), 99, 8, dummy);
    byte_xfer(8'b1110_0101, 99, 8, dummy); cs_end();
    check_eq("R12 valid held", int'(req_valid), 1);
    check_eq("R12 kind held", int'(req_kind), 5);
    repeat (20) @(negedge clk);
    check_eq("R12 still valid", int'(req_valid), 1);
    check_eq("R12 sel stable", int'(req_sel), 1);
    check_eq("R12 pot stable", int'(req_pot), 1);
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R12 accepted once", cap_n - base, 1);

    // directed step run and reads/status
    run_cmd(4'b0010, 1'b1, 2'b00, 1'b0, 8'h00, 6, 8'b0010_1011);
    wip = 1'b1; run_cmd(4'b0101, 1'b0, 2'b00, 1'b0, 8'h00, 0, 8'h00);
    run_cmd(4'b1011, 1'b1, 2'b11, 1'b0, 8'h00, 0, 8'h00);

    // constrained random frames
    for (int it = 0; it < 40; it++) begin
      addr_strap = 2'($urandom % 4);
      wip = 1'($urandom % 2);
      if ($urandom % 8 == 0) op = 4'($urandom % 16);
      else op = pick_op($urandom % 10);
      run_cmd(op, 1'($urandom % 2), 2'($urandom % 4), ($urandom % 10) == 0,
              8'($urandom), 1 + $urandom % 5, 8'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule